// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block derives a slow output clock, such as one near 32.768 kHz, from a much faster reference clock. One integer division ratio cannot reach such a target exactly. The block therefore alternates between two ratios. It holds the first ratio for a programmed number of output periods, then holds the second ratio for its own programmed number of periods, and repeats. The long-run average rate is the reference rate times (CA+CB) / (RA·CA + RB·CB), where RA and RB are the effective ratios and CA and CB are the effective repeat counts. A single mode is also provided, in which only the first ratio is used and the output rate is the reference rate divided by RA.

Four programmable fields set the ratios and repeat counts. Each field stores its effective value minus one. The fields and the mode select are taken in only at the boundaries where a change cannot cut a period short. A one-cycle strobe marks the first reference cycle of every output period. Downstream logic can use it as a tick, and a bench can use it to measure period lengths.

Top module: `dmod_clkdiv`

## Requirements
- R1: With `dual_sel` = 0 every output period lasts `ratio_a`+1 reference cycles. Values on `ratio_b`, `reps_a` and `reps_b` have no effect on the output in this mode.
- R2: With `dual_sel` = 1 the output gives `reps_a`+1 consecutive periods of `ratio_a`+1 cycles, then `reps_b`+1 consecutive periods of `ratio_b`+1 cycles, and repeats this dual cycle.
- R3: Every field encodes its effective value minus one. Field value 0 means a ratio of 1 or a repeat count of 1, and the all-ones value of an RW-bit ratio field means 2^RW cycles.
- R4: In a period of N cycles, `clk_out` is high for the first max(1, floor(N/2)) cycles and low for the rest. N = 1 therefore gives a constantly high output.
- R5: `period_start` is high for exactly the first cycle of each output period, and `clk_out` is high in that same cycle.
- R6: The fields and the mode select are loaded at the first enabled cycle. After that they are loaded only at the end of a complete dual cycle (dual mode) or at the end of a period (single mode). Changes made at any other time take effect at the next such boundary.
- R7: If `en` is low at a clock edge, `clk_out` and `period_start` are low after that edge. When `en` returns high, the first `period_start` appears after the second edge at which `en` is high, and the sequence restarts with the first ratio.
- R8: While `rst_n` is low, `clk_out` and `period_start` are low. Once reset is released, the block behaves as in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output low and rewinds the sequence |
| dual_sel | input | 1 | 0 = single ratio, 1 = alternating ratios |
| ratio_a | input | RW | First division ratio minus one |
| ratio_b | input | RW | Second division ratio minus one |
| reps_a | input | CW | Period count for the first ratio minus one |
| reps_b | input | CW | Period count for the second ratio minus one |
| clk_out | output | 1 | Divided clock |
| period_start | output | 1 | One-cycle pulse at the first cycle of each output period |

## Verification
Three decisions can fall on one reference edge: the end of a period, the end of a repeat run and the end of a dual cycle. At that edge the block also loads new fields. The bench provokes this with ratios and repeat counts of 1, so every edge is a period end and many edges are also run ends. It also changes the fields in the middle of a dual cycle. For each period it measures the length from strobe to strobe and the high time. It compares these against a sequence worked out from the field values. A field change must appear only after the current dual cycle finishes, and it must never shorten any period.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } dmod_phase_e;
endpackage

// File: rtl/dmod_ratio_sel.sv
module dmod_ratio_sel
    import dmod_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 4
) (
    input  logic              dual,
    input  dmod_phase_e       ph,
    input  logic [RW-1:0]     ra,
    input  logic [RW-1:0]     rb,
    input  logic [CW-1:0]     ca,
    input  logic [CW-1:0]     cb,
    output logic [RW-1:0]     ratio_o,
    output logic [CW-1:0]     reps_o
);
    // Phase B only exists in dual mode; single mode always uses phase A fields.
    always_comb begin
        if (dual && ph == PH_B) begin
            ratio_o = rb;
            reps_o  = cb;
        end else begin
            ratio_o = ra;
            reps_o  = ca;
        end
    end
endmodule

// File: rtl/dmod_seq.sv
module dmod_seq
    import dmod_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dual_i,
    input  logic [RW-1:0]     ra_i,
    input  logic [RW-1:0]     rb_i,
    input  logic [CW-1:0]     ca_i,
    input  logic [CW-1:0]     cb_i,
    input  logic [RW-1:0]     cur_ratio,
    input  logic [CW-1:0]     cur_reps,
    output logic              run_o,
    output logic              dual_o,
    output dmod_phase_e       ph_o,
    output logic [RW-1:0]     ra_o,
    output logic [RW-1:0]     rb_o,
    output logic [CW-1:0]     ca_o,
    output logic [CW-1:0]     cb_o,
    output logic [RW-1:0]     cnt_o
);
    typedef struct packed {
        logic              run;
        logic              dual;
        logic [RW-1:0]     ra;
        logic [RW-1:0]     rb;
        logic [CW-1:0]     ca;
        logic [CW-1:0]     cb;
        dmod_phase_e       ph;
        logic [CW-1:0]     rep;
        logic [RW-1:0]     cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic prd_end;

    assign prd_end = seq_q.run && (seq_q.cnt == cur_ratio);

    always_comb begin
        seq_d = seq_q;
        if (!en) begin
            seq_d = '0;
        end else if (!seq_q.run || (prd_end && !seq_q.dual) ||
                     (prd_end && seq_q.rep == cur_reps && seq_q.ph == PH_B)) begin
            // load point: start, single-mode period end, dual-cycle end
            seq_d.run  = 1'b1;
            seq_d.dual = dual_i;
            seq_d.ra   = ra_i;
            seq_d.rb   = rb_i;
            seq_d.ca   = ca_i;
            seq_d.cb   = cb_i;
            seq_d.ph   = PH_A;
            seq_d.rep  = '0;
            seq_d.cnt  = '0;
        end else if (prd_end) begin
            seq_d.cnt = '0;
            if (seq_q.rep == cur_reps) begin
                seq_d.rep = '0;
                seq_d.ph  = PH_B;
            end else begin
                seq_d.rep = seq_q.rep + 1'b1;
            end
        end else begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign run_o  = seq_q.run;
    assign dual_o = seq_q.dual;
    assign ph_o   = seq_q.ph;
    assign ra_o   = seq_q.ra;
    assign rb_o   = seq_q.rb;
    assign ca_o   = seq_q.ca;
    assign cb_o   = seq_q.cb;
    assign cnt_o  = seq_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.run |-> seq_q.cnt <= cur_ratio); // R3
    AST_SINGLE_PHASE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && !seq_q.dual) |-> seq_q.ph == PH_A); // R1
    AST_REP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && seq_q.dual) |-> seq_q.rep <= cur_reps); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.run && en && !prd_end) |=>
            $stable({seq_q.dual, seq_q.ra, seq_q.rb, seq_q.ca, seq_q.cb})); // R6
endmodule

// File: rtl/dmod_wave.sv
module dmod_wave #(
    parameter int RW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic [RW-1:0]     cnt,
    input  logic [RW-1:0]     ratio,
    output logic              wave_o,
    output logic              stb_o
);
    localparam int NW = RW + 1;

    typedef struct packed {
        logic wave;
        logic stb;
    } wave_t;

    wave_t       wv_d, wv_q;
    logic [NW-1:0] len_full;
    logic [NW-1:0] hi_len;

    always_comb begin
        len_full = {1'b0, ratio} + 1'b1;
        hi_len   = len_full >> 1;
        if (hi_len == '0) hi_len = {{(NW-1){1'b0}}, 1'b1};
        wv_d.wave = en && run && ({1'b0, cnt} < hi_len);
        wv_d.stb  = en && run && (cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wv_q <= '0;
        else        wv_q <= wv_d;
    end

    assign wave_o = wv_q.wave;
    assign stb_o  = wv_q.stb;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!wv_q.wave && !wv_q.stb)); // R7
    AST_STB_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wv_q.stb |-> wv_q.wave); // R5
endmodule

// File: rtl/dmod_clkdiv.sv
module dmod_clkdiv
    import dmod_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dual_sel,
    input  logic [RW-1:0]     ratio_a,
    input  logic [RW-1:0]     ratio_b,
    input  logic [CW-1:0]     reps_a,
    input  logic [CW-1:0]     reps_b,
    output logic              clk_out,
    output logic              period_start
);
    logic              run_q;
    logic              dual_q;
    dmod_phase_e       ph_q;
    logic [RW-1:0]     ra_q, rb_q, cnt_q, cur_ratio;
    logic [CW-1:0]     ca_q, cb_q, cur_reps;

    dmod_seq #(.RW(RW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dual_i    (dual_sel),
        .ra_i      (ratio_a),
        .rb_i      (ratio_b),
        .ca_i      (reps_a),
        .cb_i      (reps_b),
        .cur_ratio (cur_ratio),
        .cur_reps  (cur_reps),
        .run_o     (run_q),
        .dual_o    (dual_q),
        .ph_o      (ph_q),
        .ra_o      (ra_q),
        .rb_o      (rb_q),
        .ca_o      (ca_q),
        .cb_o      (cb_q),
        .cnt_o     (cnt_q)
    );

    dmod_ratio_sel #(.RW(RW), .CW(CW)) u_sel (
        .dual    (dual_q),
        .ph      (ph_q),
        .ra      (ra_q),
        .rb      (rb_q),
        .ca      (ca_q),
        .cb      (cb_q),
        .ratio_o (cur_ratio),
        .reps_o  (cur_reps)
    );

    dmod_wave #(.RW(RW)) u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .run    (run_q),
        .cnt    (cnt_q),
        .ratio  (cur_ratio),
        .wave_o (clk_out),
        .stb_o  (period_start)
    );

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |-> (!clk_out && !period_start)); // R8
endmodule

// File: tb/dmod_clkdiv_bench.sv
module dmod_clkdiv_bench;
    localparam int RW = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          dual_sel = 1'b0;
    logic [RW-1:0] ratio_a = '0, ratio_b = '0;
    logic [CW-1:0] reps_a = '0, reps_b = '0;
    logic          clk_out, period_start;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    dmod_clkdiv #(.RW(RW), .CW(CW)) u_dmod_clkdiv (
        .clk(clk), .rst_n(rst_n), .en(en), .dual_sel(dual_sel),
        .ratio_a(ratio_a), .ratio_b(ratio_b), .reps_a(reps_a), .reps_b(reps_b),
        .clk_out(clk_out), .period_start(period_start)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_vec = n_vec + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act cycles %0d exp under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int exp_hi(input int n);
        return (n / 2 < 1) ? 1 : n / 2;
    endfunction

    // At a negedge showing a strobe; measure one period, return at the next strobe.
    task automatic check_period(input int exp_n, input string req);
        int len = 0;
        int hi  = 0;
        chk(period_start == 1'b1, {req, " R5 strobe at period start"}, int'(period_start), 1);
        do begin
            hi  += int'(clk_out);
            len += 1;
            @(negedge clk);
        end while (period_start == 1'b0 && len < 40);
        chk(len == exp_n, {req, " period length"}, len, exp_n);
        chk(hi == exp_hi(exp_n), {req, " R4 high time"}, hi, exp_hi(exp_n));
    endtask

    // Enable with current fields; check R7 latency; leave at first strobe.
    task automatic start_run();
        en = 1'b1;
        @(negedge clk);
        chk(period_start == 1'b0, "R7 no strobe one edge after enable", int'(period_start), 0);
        @(negedge clk);
    endtask

    task automatic stop_run();
        en = 1'b0;
        @(negedge clk);
        chk(clk_out == 1'b0 && period_start == 1'b0, "R7 idle low after disable",
            int'({clk_out, period_start}), 0);
    endtask

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk(clk_out == 1'b0 && period_start == 1'b0, "R8 outputs low in reset",
            int'({clk_out, period_start}), 0);
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 dual sweep: two full dual cycles per setting, incl. ratio 1
        dual_sel = 1'b1;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int ma = 0; ma < 3; ma++)
                    for (int mb = 0; mb < 3; mb++) begin
                        ratio_a = RW'(a); ratio_b = RW'(b);
                        reps_a = CW'(ma); reps_b = CW'(mb);
                        start_run();
                        for (int c = 0; c < 2; c++) begin
                            for (int r = 0; r <= ma; r++) check_period(a + 1, "R2 first ratio");
                            for (int r = 0; r <= mb; r++) check_period(b + 1, "R2 second ratio");
                        end
                        stop_run();
                    end

        // R1 R3 single sweep, other fields scrambled each period
        dual_sel = 1'b0;
        for (int a = 0; a < 16; a++) begin
            ratio_a = RW'(a);
            start_run();
            for (int p = 0; p < 4; p++) begin
                ratio_b = RW'(p * 5 + a);
                reps_a  = CW'(p * 3 + 1);
                reps_b  = CW'(p + a);
                check_period(a + 1, "R1 single ignores other fields");
            end
            stop_run();
        end

        // R6 capture only at dual-cycle end
        dual_sel = 1'b1; ratio_a = 4'd1; ratio_b = 4'd2; reps_a = 4'd1; reps_b = 4'd0;
        start_run();
        check_period(2, "R6 old A");
        ratio_a = 4'd3; ratio_b = 4'd0; reps_a = 4'd0; reps_b = 4'd1;
        check_period(2, "R6 old A kept");
        check_period(3, "R6 old B kept");
        for (int c = 0; c < 2; c++) begin
            check_period(4, "R6 new A");
            check_period(1, "R6 new B");
            check_period(1, "R6 new B");
        end
        dual_sel = 1'b0; ratio_a = 4'd2;
        check_period(4, "R6 dual finishes before single");
        check_period(1, "R6 dual finishes before single");
        check_period(1, "R6 dual finishes before single");
        check_period(3, "R6 single now");
        dual_sel = 1'b1; ratio_a = 4'd0; ratio_b = 4'd1; reps_a = 4'd0; reps_b = 4'd0;
        check_period(3, "R6 single period completes");
        for (int c = 0; c < 2; c++) begin
            check_period(1, "R6 dual now A");
            check_period(2, "R6 dual now B");
        end
        stop_run();

        // R7 disable in second phase, restart with first ratio
        ratio_a = 4'd1; ratio_b = 4'd3; reps_a = 4'd0; reps_b = 4'd1;
        start_run();
        check_period(2, "R7 A");
        check_period(4, "R7 B");
        @(negedge clk);
        stop_run();
        start_run();
        check_period(2, "R7 restart on first ratio");
        check_period(4, "R7 B after restart");

        // R8 reset mid-run, restart on first ratio
        rst_n = 1'b0;
        @(negedge clk);
        chk(clk_out == 1'b0 && period_start == 1'b0, "R8 low during reset",
            int'({clk_out, period_start}), 0);
        rst_n = 1'b1;
        en = 1'b0;
        @(negedge clk);
        start_run();
        check_period(2, "R8 restart on first ratio");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule